// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Tracker

Inside a DDR SDRAM controller, this block watches every read and write the scheduler sends. It records which of those commands asked for an automatic close of the row. A read or write that also drives address bit 10 high requests that close. For each bank, the block then works out when the implied precharge would take place. It treats that precharge as an explicit one placed at the earliest legal point in the burst. The bank is held "not ready" until the row-precharge time after that point has passed. The setting applies to one command only, so each read or write decides for itself.

The block also keeps a permission flag for burst terminate. Terminating a burst is legal only when the most recent accepted read did not request the automatic close. Two kinds of input are reported through a one-cycle error pulse and have no other effect: a terminate request that is not allowed, and a read or write aimed at a bank that is still closing. The block issues no commands of its own.

Top module: `ap_tracker`

## Requirements
- R1: While reset is held, and directly after it, every bit of `bankReady` is 1, and `btAllowed` and `illegalCmd` are 0.
- R2: A read is `cmdValid`=1 with `cmdType`=01. If a read has `apBit`=1 and targets a ready bank, the bank's `bankReady` goes to 0 after the command edge. It returns to 1 exactly 2^`blCode` − 1 + TRP clocks after that edge. The burst length is 2^(`blCode`+1) beats.
- R3: A write is `cmdValid`=1 with `cmdType`=10. If a write has `apBit`=1 and targets a ready bank, its `bankReady` returns to 1 exactly 2^`blCode` + TWR + TRP clocks after the command edge. This covers the last data beat, then write recovery, then TRP.
- R4: A read or write with `apBit`=0 leaves `bankReady` of its bank at 1.
- R5: A command to one bank never changes `bankReady` of any other bank.
- R6: A read or write to a bank whose `bankReady` is 0 is ignored. It does not change any bank's timing or `btAllowed`. `illegalCmd` is 1 for the one cycle after its edge.
- R7: `btAllowed` is 0 until the first accepted read. After that, it is the inverse of `apBit` on the most recent accepted read. Writes do not change it.
- R8: `btReq`=1 while `btAllowed`=0 gives `illegalCmd`=1 in the next cycle. `btReq`=1 while `btAllowed`=1 gives no error.
- R9: `cmdType` values 00 and 11 change neither `bankReady` nor `btAllowed`, even with `apBit`=1, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is issued this cycle |
| cmdType | input | 2 | 01 read, 10 write, 00/11 other |
| bankAddr | input | BANK_W | Target bank |
| apBit | input | 1 | Address bit 10: automatic precharge request |
| blCode | input | BLCODE_W | Burst length code, BL = 2^(code+1) |
| btReq | input | 1 | Burst-terminate request |
| bankReady | output | NUM_BANKS | Bank may take a new command |
| btAllowed | output | 1 | Burst terminate is currently legal |
| illegalCmd | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench builds the block with its defaults: four banks, TRP=3, TWR=2 and a two-bit burst code. With those values it can sweep every bank against every burst length, both directions and both settings of the precharge bit. Every cycle of each closing window is compared with the arithmetic delay, up to 13 clocks for the longest write. The small delays also leave room to aim a second command into the middle of a window. That tests rejection and checks that the original release time still holds.

// File: rtl/ap_tracker_pkg.sv
package ap_tracker_pkg;

  typedef enum logic [1:0] {
    CMD_OTHER = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cmdKind_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;     // start a closing window on the addressed bank
    logic isWrite;  // window length follows write timing
  } apStrobe_t;

endpackage

// File: rtl/ap_tracker_ctrl.sv
module ap_tracker_ctrl
  import ap_tracker_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdType,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apBit,
  input  logic                 btReq,
  input  logic [NUM_BANKS-1:0] bankReady,
  output apStrobe_t            strobe,
  output logic                 btAllowed,
  output logic                 illegalCmd
);

  logic isRead;
  logic isWrite;
  logic isRw;
  logic bankFree;
  logic accept;
  logic seenRead;
  logic lastReadAp;

  always_comb begin
    isRead   = cmdValid && (cmdType == CMD_READ);
    isWrite  = cmdValid && (cmdType == CMD_WRITE);
    isRw     = isRead || isWrite;
    bankFree = bankReady[bankAddr];
    accept   = isRw && bankFree;
    strobe.load    = accept && apBit;
    strobe.isWrite = isWrite;
  end

  // Remember the precharge request of the latest accepted read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenRead   <= 1'b0;
      lastReadAp <= 1'b0;
    end else if (accept && isRead) begin
      seenRead   <= 1'b1;
      lastReadAp <= apBit;
    end
  end

  assign btAllowed = seenRead && !lastReadAp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalCmd <= 1'b0;
    else       illegalCmd <= (isRw && !bankFree) || (btReq && !btAllowed);
  end

endmodule

// File: rtl/ap_tracker_datapath.sv
module ap_tracker_datapath
  import ap_tracker_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int BLCODE_W  = 2,
  parameter int TRP       = 3,
  parameter int TWR       = 2,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  apStrobe_t            strobe,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [BLCODE_W-1:0]  blCode,
  output logic [NUM_BANKS-1:0] bankReady
);

  logic [CNT_W-1:0] halfBurst;
  logic [CNT_W-1:0] delay;

  // Read: precharge point at half burst minus one, then TRP.
  // Write: last beat at half burst, plus recovery, then TRP.
  always_comb begin
    halfBurst = CNT_W'(1) << blCode;
    if (strobe.isWrite) delay = halfBurst + CNT_W'(TWR + TRP);
    else                delay = halfBurst + CNT_W'(TRP - 1);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        remain <= '0;
      else if (strobe.load && (bankAddr == BANK_W'(b)))
        remain <= delay;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end

    assign bankReady[b] = (remain == '0);
  end

endmodule

// File: rtl/ap_tracker.sv
module ap_tracker
  import ap_tracker_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BLCODE_W  = 2,
  parameter  int TRP       = 3,
  parameter  int TWR       = 2,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int MAX_HALF  = 1 << ((1 << BLCODE_W) - 1),
  localparam int MAX_DELAY = MAX_HALF + TWR + TRP,
  localparam int CNT_W     = $clog2(MAX_DELAY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdType,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apBit,
  input  logic [BLCODE_W-1:0]  blCode,
  input  logic                 btReq,
  output logic [NUM_BANKS-1:0] bankReady,
  output logic                 btAllowed,
  output logic                 illegalCmd
);

  apStrobe_t strobe;

  ap_tracker_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdType   (cmdType),
    .bankAddr  (bankAddr),
    .apBit     (apBit),
    .btReq     (btReq),
    .bankReady (bankReady),
    .strobe    (strobe),
    .btAllowed (btAllowed),
    .illegalCmd(illegalCmd)
  );

  ap_tracker_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .BLCODE_W (BLCODE_W),
    .TRP      (TRP),
    .TWR      (TWR),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bankAddr (bankAddr),
    .blCode   (blCode),
    .bankReady(bankReady)
  );

endmodule

// File: rtl/ap_tracker_checker.sv
module ap_tracker_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [1:0]           cmdType,
  input logic [BANK_W-1:0]    bankAddr,
  input logic                 apBit,
  input logic                 btReq,
  input logic [NUM_BANKS-1:0] bankReady,
  input logic                 btAllowed,
  input logic                 illegalCmd
);

  logic rdCmd;
  logic wrCmd;
  assign rdCmd = cmdValid && (cmdType == 2'b01);
  assign wrCmd = cmdValid && (cmdType == 2'b10);

  a_r2_read_closes_bank: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && apBit && bankReady[bankAddr]) |=> !bankReady[$past(bankAddr)]);

  a_r3_write_closes_bank: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && apBit && bankReady[bankAddr]) |=> !bankReady[$past(bankAddr)]);

  a_r4_plain_keeps_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((rdCmd || wrCmd) && !apBit && bankReady[bankAddr]) |=> bankReady[$past(bankAddr)]);

  a_r6_busy_flagged: assert property (@(posedge clk) disable iff (!rstN)
    ((rdCmd || wrCmd) && !bankReady[bankAddr]) |=> illegalCmd);

  a_r7_only_reads_move_permission: assert property (@(posedge clk) disable iff (!rstN)
    !rdCmd |=> $stable(btAllowed));

  a_r8_bad_terminate_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (btReq && !btAllowed) |=> illegalCmd);

endmodule

bind ap_tracker ap_tracker_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdType   (cmdType),
  .bankAddr  (bankAddr),
  .apBit     (apBit),
  .btReq     (btReq),
  .bankReady (bankReady),
  .btAllowed (btAllowed),
  .illegalCmd(illegalCmd)
);

// File: tb/ap_tracker_bench.sv
module ap_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int TRP = 3;
  localparam int TWR = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdValid;
  logic [1:0]    cmdType;
  logic [1:0]    bankAddr;
  logic          apBit;
  logic [1:0]    blCode;
  logic          btReq;
  logic [NB-1:0] bankReady;
  logic          btAllowed;
  logic          illegalCmd;

  int vecCount = 0;
  int errCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ap_tracker #(.NUM_BANKS(NB), .BLCODE_W(2), .TRP(TRP), .TWR(TWR)) u_ap_tracker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .bankAddr(bankAddr), .apBit(apBit), .blCode(blCode), .btReq(btReq),
    .bankReady(bankReady), .btAllowed(btAllowed), .illegalCmd(illegalCmd)
  );

  task automatic check(input string tag, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expDelay(input bit isW, input int code);
    return isW ? (1 << code) + TWR + TRP : (1 << code) - 1 + TRP;
  endfunction

  task automatic clearInputs();
    cmdValid = 0; cmdType = 2'b00; bankAddr = 0; apBit = 0; blCode = 0; btReq = 0;
  endtask

  // Called at a negedge; returns at the negedge after the command edge
  task automatic issue(input logic [1:0] kind, input int bank, input int code, input bit ap);
    cmdValid = 1; cmdType = kind; bankAddr = 2'(bank); blCode = 2'(code); apBit = ap;
    @(negedge clk);
    clearInputs();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errCount++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    rstN = 0;
    clearInputs();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 ready", int'(bankReady), (1 << NB) - 1);
    check("R1 btAllowed", int'(btAllowed), 0);
    check("R1 illegal", int'(illegalCmd), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 ready after release", int'(bankReady), (1 << NB) - 1);

    // R8: terminate before any read
    btReq = 1;
    @(negedge clk);
    btReq = 0;
    check("R8 early terminate flagged", int'(illegalCmd), 1);
    @(negedge clk);
    check("R8 pulse one cycle", int'(illegalCmd), 0);

    // Sweep: banks x burst codes x direction x precharge bit
    for (int bank = 0; bank < NB; bank++)
      for (int code = 0; code < 4; code++)
        for (int w = 0; w < 2; w++)
          for (int ap = 0; ap < 2; ap++) begin
            int d;
            int prevBt;
            string tag;
            d = expDelay(w[0], code);
            prevBt = int'(btAllowed);
            tag = (ap == 0) ? "R4" : (w == 1 ? "R3" : "R2");
            issue(w ? 2'b10 : 2'b01, bank, code, ap[0]);
            for (int j = 0; j <= d + 1; j++) begin
              int expBit;
              expBit = (ap == 1 && j < d) ? 0 : 1;
              check(tag, int'(bankReady[bank]), expBit);
              check("R5 other banks", int'(bankReady | (NB'(1) << bank)), (1 << NB) - 1);
              check("R6 no spurious error", int'(illegalCmd), 0);
              if (j == 0)
                check("R7 permission", int'(btAllowed), (w == 0) ? (ap == 0 ? 1 : 0) : prevBt);
              @(negedge clk);
            end
          end

    // R6: AP read to bank 1 (code 1, delay 4), then a plain read into the window
    issue(2'b01, 1, 1, 1'b1);
    check("R2 closed", int'(bankReady[1]), 0);
    check("R7 after ap read", int'(btAllowed), 0);
    issue(2'b01, 1, 0, 1'b0);                         // j=1 sampled
    check("R6 busy read flagged", int'(illegalCmd), 1);
    check("R6 permission untouched", int'(btAllowed), 0);
    issue(2'b10, 1, 3, 1'b1);                         // j=2
    check("R6 busy write flagged", int'(illegalCmd), 1);
    check("R6 still closed", int'(bankReady[1]), 0);
    @(negedge clk);                                   // j=3
    check("R6 window unchanged j3", int'(bankReady[1]), 0);
    @(negedge clk);                                   // j=4
    check("R6 window unchanged j4", int'(bankReady[1]), 1);
    check("R6 error cleared", int'(illegalCmd), 0);

    // R8 with permission denied, then granted
    btReq = 1;
    @(negedge clk);
    btReq = 0;
    check("R8 denied terminate", int'(illegalCmd), 1);
    issue(2'b01, 2, 2, 1'b0);
    check("R7 plain read grants", int'(btAllowed), 1);
    btReq = 1;
    @(negedge clk);
    btReq = 0;
    check("R8 allowed terminate", int'(illegalCmd), 0);

    // R9: other command codes with the precharge bit set
    for (int k = 0; k < 2; k++) begin
      issue(k == 0 ? 2'b00 : 2'b11, 3, 3, 1'b1);
      check("R9 ready kept", int'(bankReady), (1 << NB) - 1);
      check("R9 permission kept", int'(btAllowed), 1);
      check("R9 no error", int'(illegalCmd), 0);
    end

    // R1: reset mid-window returns everything to idle
    issue(2'b10, 0, 3, 1'b1);
    issue(2'b01, 3, 0, 1'b1);
    rstN = 0;
    @(negedge clk);
    check("R1 reset clears windows", int'(bankReady), (1 << NB) - 1);
    check("R1 reset clears permission", int'(btAllowed), 0);
    rstN = 1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule